// File: doc/BRIEF.md
# Read/Write Command Channel Arbiter

This block sits in front of a memory controller that accepts one command stream. Two address request channels arrive on their own valid/ready handshakes: one for reads and one for writes. Each carries an address, a transaction ID, a burst length, a beat size and a burst type. The block picks one of them per transfer and presents it on a single valid/ready command port, tagged with a direction bit.

The merge adds no latency. The output is a combinational selection of the chosen input, so a command can pass in the cycle it arrives, and commands can follow one another every cycle. A build-time parameter fixes the policy used when both channels request at once:
- alternating grants (round robin),
- writes first,
- reads first.

When the command port stalls, the block freezes its choice. The presented command then stays put until the port accepts it.

Top module: `cmd_arb`

## Requirements
- R1: Whenever either input channel has its valid high, `cmd_valid` is high in the same cycle.
- R2: If exactly one channel is valid and no stalled command is being held, that channel is presented, whatever the policy.
- R3: With POLICY = POL_ROUND_ROBIN and both channels valid, the direction presented is the opposite of the last accepted command. After reset the last accepted direction counts as write, so the first contested grant goes to read.
- R4: With POLICY = POL_WRITE_FIRST and both channels valid, the write channel is presented.
- R5: With POLICY = POL_READ_FIRST and both channels valid, the read channel is presented.
- R6: If `cmd_valid` is high and `cmd_ready` is low, the next cycle presents the same direction with its payload unchanged. This holds even when the other channel has since raised a request that would otherwise win.
- R7: The round-robin last-granted state changes only in a cycle where `cmd_valid` and `cmd_ready` are both high, and it then records that command's direction.
- R8: `cmd_is_write` is 1 for a command from the write channel and 0 for one from the read channel. The address, ID, length, size and burst fields are copied unchanged from the chosen channel.
- R9: `rd_ready` (`wr_ready`) is high only in a cycle where a read (write) command is transferred, meaning `cmd_valid`, `cmd_ready` and the matching direction are all true. The two are never high together.
- R10: While `rst_n` is low, and right after reset with no requests, `cmd_valid`, `rd_ready` and `wr_ready` are low. Reset also returns the round-robin state to its initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | ADDR_W | Read start address |
| rd_id | input | ID_W | Read transaction ID |
| rd_len | input | LEN_W | Read burst length |
| rd_size | input | SIZE_W | Read beat size code |
| rd_burst | input | BURST_W | Read burst type |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | ADDR_W | Write start address |
| wr_id | input | ID_W | Write transaction ID |
| wr_len | input | LEN_W | Write burst length |
| wr_size | input | SIZE_W | Write beat size code |
| wr_burst | input | BURST_W | Write burst type |
| cmd_valid | output | 1 | Merged command valid |
| cmd_ready | input | 1 | Merged command accepted by downstream |
| cmd_is_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_id | output | ID_W | Command ID |
| cmd_len | output | LEN_W | Command burst length |
| cmd_size | output | SIZE_W | Command beat size code |
| cmd_burst | output | BURST_W | Command burst type |

## Verification
The hardest case to reach is a held grant that overrides the policy. It needs three things in a row:
- a lone request,
- a stall on the command port,
- a competing request that would normally win, arriving while the first is still held.

The stimulus table builds this sequence explicitly, for both a held read and a held write. It runs against three instances, one per policy, on shared inputs. A separate step sets the round-robin state to read, then resets mid-run, to show the first contested grant still goes to read.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;

  typedef enum logic [1:0] {
    POL_ROUND_ROBIN = 2'd0,
    POL_WRITE_FIRST = 2'd1,
    POL_READ_FIRST  = 2'd2
  } arb_policy_e;

  // Decide the direction to present when no command is held.
  // Returns 1 for the write channel, 0 for read (or for no request).
  function automatic logic pick_write(arb_policy_e pol, logic rv, logic wv,
                                      logic last_wr);
    logic w;
    if (wv && !rv)       w = 1'b1;
    else if (!wv)        w = 1'b0;
    else begin
      case (pol)
        POL_WRITE_FIRST: w = 1'b1;
        POL_READ_FIRST:  w = 1'b0;
        default:         w = ~last_wr;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/cmd_arb_select.sv
module cmd_arb_select
  import cmd_arb_pkg::*;
#(
  parameter arb_policy_e POLICY = POL_ROUND_ROBIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic wr_valid,
  input  logic cmd_ready,
  input  logic last_wr,
  output logic grant_write,
  output logic cmd_valid,
  output logic hold_active
);

  logic hold_q;
  logic hold_dir_q;
  logic fresh_write;
  logic stall;

  assign fresh_write = pick_write(POLICY, rd_valid, wr_valid, last_wr);
  assign grant_write = hold_q ? hold_dir_q : fresh_write;
  assign cmd_valid   = grant_write ? wr_valid : rd_valid;
  assign stall       = cmd_valid && !cmd_ready;
  assign hold_active = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_dir_q <= 1'b0;
    end else begin
      hold_q <= stall;
      if (stall) hold_dir_q <= grant_write;
    end
  end

endmodule

// File: rtl/cmd_arb_rr_ptr.sv
module cmd_arb_rr_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accepted_write,
  output logic last_wr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_wr <= 1'b1;
    else if (accept) last_wr <= accepted_write;
  end

endmodule

// File: rtl/cmd_arb_mux.sv
module cmd_arb_mux #(
  parameter int W = 8
) (
  input  logic         sel_b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  assign y = sel_b ? b : a;

endmodule

// File: rtl/cmd_arb.sv
module cmd_arb
  import cmd_arb_pkg::*;
#(
  parameter arb_policy_e POLICY  = POL_ROUND_ROBIN,
  parameter int          ADDR_W  = 32,
  parameter int          ID_W    = 4,
  parameter int          LEN_W   = 8,
  parameter int          SIZE_W  = 3,
  parameter int          BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [ID_W-1:0]    rd_id,
  input  logic [LEN_W-1:0]   rd_len,
  input  logic [SIZE_W-1:0]  rd_size,
  input  logic [BURST_W-1:0] rd_burst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [SIZE_W-1:0]  wr_size,
  input  logic [BURST_W-1:0] wr_burst,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_is_write,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [ID_W-1:0]    cmd_id,
  output logic [LEN_W-1:0]   cmd_len,
  output logic [SIZE_W-1:0]  cmd_size,
  output logic [BURST_W-1:0] cmd_burst
);

  localparam int PAY_W = ADDR_W + ID_W + LEN_W + SIZE_W + BURST_W;

  logic             grant_write;
  logic             hold_active;
  logic             accept;
  logic             last_wr;
  logic [PAY_W-1:0] rd_pay;
  logic [PAY_W-1:0] wr_pay;
  logic [PAY_W-1:0] cmd_pay;

  cmd_arb_select #(.POLICY(POLICY)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .wr_valid    (wr_valid),
    .cmd_ready   (cmd_ready),
    .last_wr     (last_wr),
    .grant_write (grant_write),
    .cmd_valid   (cmd_valid),
    .hold_active (hold_active)
  );

  assign accept = cmd_valid && cmd_ready;

  generate
    if (POLICY == POL_ROUND_ROBIN) begin : g_rr
      cmd_arb_rr_ptr u_ptr (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .accepted_write (grant_write),
        .last_wr        (last_wr)
      );
    end else begin : g_fixed
      assign last_wr = 1'b0;
    end
  endgenerate

  assign rd_pay = {rd_addr, rd_id, rd_len, rd_size, rd_burst};
  assign wr_pay = {wr_addr, wr_id, wr_len, wr_size, wr_burst};

  cmd_arb_mux #(.W(PAY_W)) u_mux (
    .sel_b (grant_write),
    .a     (rd_pay),
    .b     (wr_pay),
    .y     (cmd_pay)
  );

  assign {cmd_addr, cmd_id, cmd_len, cmd_size, cmd_burst} = cmd_pay;
  assign cmd_is_write = grant_write;
  assign rd_ready     = accept && !grant_write;
  assign wr_ready     = accept && grant_write;

endmodule

// File: rtl/cmd_arb_checker.sv
module cmd_arb_checker
  import cmd_arb_pkg::*;
#(
  parameter arb_policy_e POLICY = POL_ROUND_ROBIN
) (
  input logic clk,
  input logic rst_n,
  input logic rd_valid,
  input logic wr_valid,
  input logic rd_ready,
  input logic wr_ready,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_is_write,
  input logic hold_active,
  input logic accept,
  input logic last_wr
);

  localparam logic IS_RR = (POLICY == POL_ROUND_ROBIN);
  localparam logic IS_WF = (POLICY == POL_WRITE_FIRST);
  localparam logic IS_RF = (POLICY == POL_READ_FIRST);

  assert_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_valid) |-> cmd_valid);

  assert_lone_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_active && rd_valid && !wr_valid) |-> (cmd_valid && !cmd_is_write));

  assert_lone_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_active && wr_valid && !rd_valid) |-> (cmd_valid && cmd_is_write));

  assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_RR && !hold_active && rd_valid && wr_valid) |-> (cmd_is_write == !last_wr));

  assert_write_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_WF && !hold_active && rd_valid && wr_valid) |-> cmd_is_write);

  assert_read_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_RF && !hold_active && rd_valid && wr_valid) |-> !cmd_is_write);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && cmd_is_write == $past(cmd_is_write)));

  assert_ptr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(last_wr));

  assert_ptr_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_RR && accept) |=> (last_wr == $past(cmd_is_write)));

  assert_ready_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && wr_ready));

  assert_rd_ready_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (cmd_valid && cmd_ready && !cmd_is_write));

  assert_wr_ready_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (cmd_valid && cmd_ready && cmd_is_write));

endmodule

bind cmd_arb cmd_arb_checker #(.POLICY(POLICY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_valid     (rd_valid),
  .wr_valid     (wr_valid),
  .rd_ready     (rd_ready),
  .wr_ready     (wr_ready),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_is_write (cmd_is_write),
  .hold_active  (hold_active),
  .accept       (accept),
  .last_wr      (last_wr)
);

// File: tb/cmd_arb_test.sv
module cmd_arb_test;
  import cmd_arb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rd_valid = 0, wr_valid = 0, cmd_ready = 0;
  logic [31:0] rd_addr = 0, wr_addr = 0;
  logic [3:0]  rd_id = 0, wr_id = 0;
  logic [7:0]  rd_len = 0, wr_len = 0;
  logic [2:0]  rd_size = 0, wr_size = 0;
  logic [1:0]  rd_burst = 0, wr_burst = 0;

  // one output bundle per policy: index 0 round robin, 1 write first, 2 read first
  logic        o_valid [3];
  logic        o_wr    [3];
  logic        o_rrdy  [3];
  logic        o_wrdy  [3];
  logic [31:0] o_addr  [3];
  logic [3:0]  o_id    [3];
  logic [7:0]  o_len   [3];
  logic [2:0]  o_size  [3];
  logic [1:0]  o_burst [3];

  cmd_arb #(.POLICY(POL_ROUND_ROBIN)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(o_rrdy[0]), .rd_addr(rd_addr), .rd_id(rd_id),
    .rd_len(rd_len), .rd_size(rd_size), .rd_burst(rd_burst),
    .wr_valid(wr_valid), .wr_ready(o_wrdy[0]), .wr_addr(wr_addr), .wr_id(wr_id),
    .wr_len(wr_len), .wr_size(wr_size), .wr_burst(wr_burst),
    .cmd_valid(o_valid[0]), .cmd_ready(cmd_ready), .cmd_is_write(o_wr[0]),
    .cmd_addr(o_addr[0]), .cmd_id(o_id[0]), .cmd_len(o_len[0]),
    .cmd_size(o_size[0]), .cmd_burst(o_burst[0]));

  cmd_arb #(.POLICY(POL_WRITE_FIRST)) uut_wf (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(o_rrdy[1]), .rd_addr(rd_addr), .rd_id(rd_id),
    .rd_len(rd_len), .rd_size(rd_size), .rd_burst(rd_burst),
    .wr_valid(wr_valid), .wr_ready(o_wrdy[1]), .wr_addr(wr_addr), .wr_id(wr_id),
    .wr_len(wr_len), .wr_size(wr_size), .wr_burst(wr_burst),
    .cmd_valid(o_valid[1]), .cmd_ready(cmd_ready), .cmd_is_write(o_wr[1]),
    .cmd_addr(o_addr[1]), .cmd_id(o_id[1]), .cmd_len(o_len[1]),
    .cmd_size(o_size[1]), .cmd_burst(o_burst[1]));

  cmd_arb #(.POLICY(POL_READ_FIRST)) uut_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(o_rrdy[2]), .rd_addr(rd_addr), .rd_id(rd_id),
    .rd_len(rd_len), .rd_size(rd_size), .rd_burst(rd_burst),
    .wr_valid(wr_valid), .wr_ready(o_wrdy[2]), .wr_addr(wr_addr), .wr_id(wr_id),
    .wr_len(wr_len), .wr_size(wr_size), .wr_burst(wr_burst),
    .cmd_valid(o_valid[2]), .cmd_ready(cmd_ready), .cmd_is_write(o_wr[2]),
    .cmd_addr(o_addr[2]), .cmd_id(o_id[2]), .cmd_len(o_len[2]),
    .cmd_size(o_size[2]), .cmd_burst(o_burst[2]));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // {rd_valid, wr_valid, cmd_ready, rr_v, rr_w, wf_v, wf_w, rf_v, rf_w}
  localparam logic [8:0] VEC [16] = '{
    9'b001_00_00_00,  // idle
    9'b101_10_10_10,  // lone read R2
    9'b011_11_11_11,  // lone write R2
    9'b111_10_11_10,  // contest: R3 read (last write), R4, R5
    9'b111_11_11_10,  // R3 alternates to write
    9'b111_10_11_10,  // R3 back to read
    9'b110_11_11_10,  // stall, grants held
    9'b110_11_11_10,  // still stalled, R6 same
    9'b111_11_11_10,  // accepted; R7 pointer only moves now
    9'b111_10_11_10,  // R3 read after accepted write
    9'b100_10_10_10,  // lone read stalls
    9'b110_10_10_10,  // R6 write arrives, held read wins in all
    9'b111_10_10_10,  // held read accepted
    9'b010_11_11_11,  // lone write stalls
    9'b111_11_11_11,  // R6 held write wins even read-first
    9'b000_00_00_00   // idle
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #4;
    for (int k = 0; k < 3; k++) begin
      chk("R10 valid in reset", {31'd0, o_valid[k]}, 32'd0);
      chk("R10 ready in reset", {30'd0, o_rrdy[k], o_wrdy[k]}, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk("R10 idle after reset", {31'd0, o_valid[0]}, 32'd0);

    // table walk
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {rd_valid, wr_valid, cmd_ready} = VEC[i][8:6];
      rd_addr = 32'h1000_0000 + i;
      wr_addr = 32'h2000_0000 + i;
      #4;
      for (int k = 0; k < 3; k++) begin
        logic ev, ew;
        ev = VEC[i][5-2*k];
        ew = VEC[i][4-2*k];
        chk($sformatf("R1 R2 R3 R4 R5 R6 valid vec%0d pol%0d", i, k),
            {31'd0, o_valid[k]}, {31'd0, ev});
        if (ev) begin
          chk($sformatf("R3 R4 R5 R6 dir vec%0d pol%0d", i, k),
              {31'd0, o_wr[k]}, {31'd0, ew});
          chk($sformatf("R8 addr vec%0d pol%0d", i, k),
              o_addr[k], ew ? wr_addr : rd_addr);
        end
        chk($sformatf("R9 ready vec%0d pol%0d", i, k),
            {30'd0, o_rrdy[k], o_wrdy[k]},
            {30'd0, ev && !ew && cmd_ready, ev && ew && cmd_ready});
      end
    end

    // R8: all payload fields, each direction
    @(negedge clk);
    rd_id = 4'h5; rd_len = 8'h03; rd_size = 3'd2; rd_burst = 2'd2; rd_addr = 32'hAAAA_0000;
    wr_id = 4'hC; wr_len = 8'h0F; wr_size = 3'd3; wr_burst = 2'd1; wr_addr = 32'hBBBB_0000;
    rd_valid = 1; wr_valid = 0; cmd_ready = 1;
    #4;
    chk("R8 read fields", {o_addr[0][31:16], o_id[0], o_len[0], o_size[0], o_burst[0], 1'b0, o_wr[0]},
        {16'hAAAA, 4'h5, 8'h03, 3'd2, 2'd2, 1'b0, 1'b0});
    @(negedge clk);
    rd_valid = 0; wr_valid = 1;
    #4;
    chk("R8 write fields", {o_addr[0][31:16], o_id[0], o_len[0], o_size[0], o_burst[0], 1'b0, o_wr[0]},
        {16'hBBBB, 4'hC, 8'h0F, 3'd3, 2'd1, 1'b0, 1'b1});

    // R7 / R10: pointer rests on read, reset must restore it
    @(negedge clk);
    rd_valid = 1; wr_valid = 0;        // read accepted: last = read
    @(negedge clk);
    rd_valid = 0;
    rst_n = 1'b0;
    #4;
    chk("R10 mid-run reset valid", {31'd0, o_valid[0]}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_valid = 1; wr_valid = 1; cmd_ready = 1;
    #4;
    chk("R10 R3 first contest after reset is read", {30'd0, o_valid[0], o_wr[0]}, 32'b10);
    @(negedge clk);
    #4;
    chk("R7 R3 next contest is write", {30'd0, o_valid[0], o_wr[0]}, 32'b11);

    // R7: stall with both waiting does not move the pointer
    @(negedge clk);
    cmd_ready = 0;                      // presents read (last = write)
    #4;
    chk("R7 stall presents read", {31'd0, o_wr[0]}, 32'd0);
    repeat (2) @(negedge clk);
    cmd_ready = 1;
    #4;
    chk("R6 held read after stall", {30'd0, o_wr[0], o_rrdy[0]}, 32'b01);
    @(negedge clk);
    #4;
    chk("R7 write follows accepted read", {31'd0, o_wr[0]}, 32'd1);

    @(negedge clk);
    rd_valid = 0; wr_valid = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule